// File: doc/BRIEF.md
# Clock Fan-Out Stage with Synchronous Per-Output Enable

This block drives several copies of one input clock. Each copy is a true/complement pair that can be switched on or off through its own enable pin. A pin's level is captured only on falling edges of the input clock. It passes through a short falling-edge synchronizer and then into a small per-output state machine. Because of this, a copy starts or stops only while the clock is low, so every high pulse it emits lasts a full clock-high phase.

A per-output format bit sets the levels a copy holds while it is off. A differential copy parks with the true line low and the complement line high. A single-ended copy parks with both lines low. A build-time mask marks enable pins that have no connection on the board. A masked copy counts as enabled whatever its pin carries.

Each output owns one state machine with two states. `CH_IDLE` holds the parked levels. `CH_RUN` passes the clock to the true line and its inverse to the complement line. There are two transitions, both taken on a falling clock edge. *Start* goes from `CH_IDLE` to `CH_RUN` when the synchronized enable is high. *Stop* goes from `CH_RUN` to `CH_IDLE` when the synchronized enable is low. An active-low asynchronous reset forces `CH_IDLE` and clears the synchronizer.

Top module: `clkoe_fanout`

## Requirements
- R1: An enable pin is captured only at falling clock edges. A change made during a clock-high phase, before falling edge F1, is not yet visible in the clock-high phase between F1 and the next falling edge F2. It shows from the clock-high phase after F2 onward.
- R2: An enabled output drives `q_true` equal to `clk` and `q_comp` equal to the inverse of `clk`.
- R3: A disabled output whose format bit is 1 (differential) holds `q_true` at 0 and `q_comp` at 1.
- R4: A disabled output whose format bit is 0 (single-ended) holds both `q_true` and `q_comp` at 0.
- R5: `q_true` is never high while `clk` is low. An output changes between running and parked only at a falling edge, so no shortened pulse is emitted.
- R6: Each output follows only its own enable pin and format bit; any mix of enabled and disabled outputs is honoured bit by bit.
- R7: An output whose bit is set in the parameter `FLOAT_MASK` behaves as enabled whatever its enable pin carries.
- R8: While `rst_n` is low, every output is parked at the level for its format. After release, enabled outputs start with the same latency as R1, counted from the release.
- R9: Changing a format bit while its output is enabled leaves that output's `q_true` and `q_comp` unchanged.
- R10: An enable pin that goes low and comes back high inside one clock-high phase, between two falling edges, does not stop its output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; copied to the outputs, and its falling edge samples the enables |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe | input | NUM_OUT | Per-output enable, active high |
| fmt | input | NUM_OUT | Per-output format: 1 differential, 0 single-ended |
| q_true | output | NUM_OUT | True output of each copy |
| q_comp | output | NUM_OUT | Complement output of each copy |

## Verification
With the default synchronizer depth, an enable change made during a clock-high phase first reaches the outputs in the clock-high phase that follows the second falling edge after the change. Reset release follows the same count. The bench drives inputs 1 ns after a rising edge. It checks the old levels in the clock-high phase between the two falling edges, then checks the new levels 1 ns into the next clock-high phase and 1 ns into the clock-low phase after it. Format changes act on parked outputs at once, and reset acts at once, so those levels are checked 1 ns after the stimulus. A latency property compares the levels seen in each clock-high phase with the enable pins sampled two falling edges earlier. It is held back for the first two falling edges after reset.

// File: rtl/clkoe_pkg.sv
`timescale 1ns/1ps
package clkoe_pkg;

    // Per-output gate state
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } chan_state_t;

    // Format bit encoding
    localparam logic FMT_SINGLE = 1'b0;
    localparam logic FMT_DIFF   = 1'b1;

endpackage

// File: rtl/clkoe_sync.sv
`timescale 1ns/1ps
// Falling-edge synchronizer chain for one enable bit.
module clkoe_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/clkoe_chan.sv
`timescale 1ns/1ps
// One output copy: synchronizer, gate state machine, output levels.
module clkoe_chan
    import clkoe_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_raw,
    input  logic fmt_bit,
    output logic q_true,
    output logic q_comp
);

    localparam int CHAIN_LEN = (SYNC_DEPTH > 1) ? SYNC_DEPTH - 1 : 1;

    logic        en_sync;
    chan_state_t state_q;
    chan_state_t state_d;

    clkoe_sync #(
        .STAGES (CHAIN_LEN)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (en_raw),
        .q     (en_sync)
    );

    // State register: moves only while the clock falls
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: start and stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (en_sync)  state_d = CH_RUN;
            CH_RUN:  if (!en_sync) state_d = CH_IDLE;
        endcase
    end

    // Output levels
    always_comb begin
        q_true = 1'b0;
        q_comp = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                q_true = 1'b0;
                q_comp = (fmt_bit == FMT_DIFF);
            end
            CH_RUN: begin
                q_true = clk;
                q_comp = ~clk;
            end
        endcase
    end

endmodule

// File: rtl/clkoe_fanout.sv
`timescale 1ns/1ps
// Clock fan-out with synchronous per-output enables.
module clkoe_fanout #(
    parameter int                  NUM_OUT    = 6,
    parameter int                  SYNC_DEPTH = 2,
    parameter logic [NUM_OUT-1:0]  FLOAT_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] oe,
    input  logic [NUM_OUT-1:0] fmt,
    output logic [NUM_OUT-1:0] q_true,
    output logic [NUM_OUT-1:0] q_comp
);

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            logic en_eff;
            assign en_eff = oe[i] | FLOAT_MASK[i];

            clkoe_chan #(
                .SYNC_DEPTH (SYNC_DEPTH)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_raw  (en_eff),
                .fmt_bit (fmt[i]),
                .q_true  (q_true[i]),
                .q_comp  (q_comp[i])
            );
        end
    endgenerate

endmodule

// File: rtl/clkoe_fanout_chk.sv
`timescale 1ns/1ps
module clkoe_fanout_chk #(
    parameter int                 NUM_OUT    = 6,
    parameter logic [NUM_OUT-1:0] FLOAT_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OUT-1:0] oe,
    input logic [NUM_OUT-1:0] fmt,
    input logic [NUM_OUT-1:0] q_true,
    input logic [NUM_OUT-1:0] q_comp
);

    logic [1:0] fall_cnt;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)                fall_cnt <= 2'd0;
        else if (fall_cnt != 2'd3) fall_cnt <= fall_cnt + 2'd1;
    end

    // R5
    low_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_true == '0);

    // R3
    diff_pair_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ((q_true ^ q_comp) | ~fmt) == '1);

    // R3
    diff_comp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_comp | ~fmt) == '1);

    // R4
    single_comp_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (q_comp & ~fmt) == '0);

    // R1
    enable_latency_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (fall_cnt >= 2'd2) |-> (q_true == ($past(oe, 2) | FLOAT_MASK)));

    // R8
    reset_idle_chk: assert property (@(negedge clk)
        !rst_n |-> (q_true == '0 && q_comp == fmt));

endmodule

bind clkoe_fanout clkoe_fanout_chk #(
    .NUM_OUT    (NUM_OUT),
    .FLOAT_MASK (FLOAT_MASK)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe     (oe),
    .fmt    (fmt),
    .q_true (q_true),
    .q_comp (q_comp)
);

// File: tb/tb_clkoe_fanout.sv
`timescale 1ns/1ps
module tb_clkoe_fanout;

    localparam int             N    = 6;
    localparam logic [N-1:0]   MASK = 6'b100000;
    localparam int             NVEC = 7;
    // each entry: {oe, fmt}
    localparam logic [2*N-1:0] VEC [NVEC] = '{
        {6'b111111, 6'b000000},
        {6'b000000, 6'b111111},
        {6'b101010, 6'b110011},
        {6'b010101, 6'b001100},
        {6'b000000, 6'b000000},
        {6'b011110, 6'b100001},
        {6'b111111, 6'b101010}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] oe = '0;
    logic [N-1:0] fmt = 6'b010110;
    logic [N-1:0] q_true;
    logic [N-1:0] q_comp;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    clkoe_fanout #(
        .NUM_OUT    (N),
        .SYNC_DEPTH (2),
        .FLOAT_MASK (MASK)
    ) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe     (oe),
        .fmt    (fmt),
        .q_true (q_true),
        .q_comp (q_comp)
    );

    function automatic logic [N-1:0] exp_t(input logic [N-1:0] en, input bit high);
        return high ? en : '0;
    endfunction

    function automatic logic [N-1:0] exp_c(input logic [N-1:0] en, input logic [N-1:0] f,
                                           input bit high);
        return (en & {N{~high}}) | (~en & f);
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] en, input bit high);
        logic [N-1:0] et, ec;
        et = exp_t(en, high);
        ec = exp_c(en, fmt, high);
        checks++;
        if (q_true !== et || q_comp !== ec) begin
            errors++;
            $display("FAIL %s: true=%b comp=%b expected true=%b comp=%b",
                     tag, q_true, q_comp, et, ec);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] prev_en;
        logic [N-1:0] new_en;

        // R8 reset state, both phases
        @(posedge clk); #1;
        chk("R8 reset high", '0, 1'b1);
        @(negedge clk); #1;
        chk("R8 reset low", '0, 1'b0);

        // release with all pins low; only masked output runs (R7)
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        chk("R7 masked output after release", MASK, 1'b1);
        prev_en = MASK;

        // table walk: R1 R2 R3 R4 R6 R7
        for (int k = 0; k < NVEC; k++) begin
            @(posedge clk); #1;
            oe  = VEC[k][2*N-1:N];
            fmt = VEC[k][N-1:0];
            new_en = oe | MASK;
            @(negedge clk);
            @(posedge clk); #1;
            chk($sformatf("R1 vector %0d before second fall", k), prev_en, 1'b1);
            @(negedge clk);
            @(posedge clk); #1;
            chk($sformatf("R2 R3 R4 R6 R7 vector %0d high", k), new_en, 1'b1);
            @(negedge clk); #1;
            chk($sformatf("R2 R3 R4 R5 R6 vector %0d low", k), new_en, 1'b0);
            prev_en = new_en;
        end

        // R9: format flip while all enabled
        @(posedge clk); #1;
        oe = '1;
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        fmt = ~fmt;
        #0.5;
        chk("R9 format flip high", '1, 1'b1);
        @(negedge clk); #1;
        chk("R9 format flip low", '1, 1'b0);

        // R10: short low blip inside one high phase
        @(posedge clk); #0.5;
        oe = '0;
        #1;
        oe = '1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            chk("R10 blip ignored high", '1, 1'b1);
            @(negedge clk); #1;
            chk("R10 blip ignored low", '1, 1'b0);
        end

        // R5: a disable lands only at a fall, full high phase kept
        @(posedge clk); #1;
        oe = 6'b000000;
        @(negedge clk);
        @(posedge clk); #1.2;
        chk("R5 full high phase before stop", '1, 1'b1);
        @(negedge clk); #1;
        chk("R5 stop at fall", MASK, 1'b0);

        // R8: reset mid-run in low phase, then release latency
        @(posedge clk); #1;
        oe = '1;
        fmt = 6'b001111;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        chk("R8 async reset low", '0, 1'b0);
        @(posedge clk); #1;
        chk("R8 in reset high", '0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        @(posedge clk); #1;
        chk("R8 release before second fall", '0, 1'b1);
        @(negedge clk);
        @(posedge clk); #1;
        chk("R8 release running", '1, 1'b1);
        @(negedge clk); #1;
        chk("R8 release running low", '1, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule